// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block collects a parameterized set of interrupt request lines and keeps four pieces of state for each line: an enable bit, a pending bit, an active bit and a 4-bit priority nibble. The nibble sits in the upper half of an 8-bit slot. A global grouping value splits every nibble into two parts. The upper part is the preemption field and the lower part is the sub-priority. The block continuously picks the most urgent request that is both pending and enabled. It raises a preemption request towards the core only when that request's preemption field beats the level of the handler that is currently running.

The core answers with two strobes. An acknowledge moves the offered interrupt from pending to active. A return retires the running handler, and the running level then falls back to the next active handler, so nesting unwinds in order. Software configures the block through a word-addressed register bus. The bus reaches the enable, pending and active bit banks, the priority slots, a software trigger and a key-protected grouping control word.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every enable, pending and active bit is zero, every priority nibble is zero, and the grouping value is 0. `preempt_req` is low, `run_level` reads 16 and every register reads zero.
- R2: The enable bits are set by writing ones at offset 0x000 and cleared by writing ones at offset 0x080. Zero bits have no effect. Interrupt n sits at word n>>5 (byte offset +4 per word) and bit n&31, and both offsets read back the enable bits.
- R3: A pending bit is set by a rising edge of its `irq_in` line. A line held high does not set it again. Pending bits can also be set by writing ones at 0x100 and cleared by writing ones at 0x180, with the same word and bit mapping as R2. Both offsets read the pending bits.
- R4: Writing the value n to offset 0xE00 sets the pending bit of interrupt n.
- R5: The priority of interrupt n is in the word at 0x300 + 4*(n>>2), in byte n&3, at bits 7:4 of that byte. Bits 3:0 of every byte ignore writes and read zero.
- R6: The grouping value is at bits 10:8 of the control word at offset 0xF00. A write changes it only when bits 31:16 of the write data equal 0x05FA. Writes without that key are discarded. A read returns the grouping value at bits 10:8 and zero elsewhere.
- R7: A grouping value g of 3 or below gives 4 preemption bits. A value g above 3 gives 7-g preemption bits, so 7 gives none. The preemption field is the upper bits of the nibble.
- R8: `preempt_id` names the pending and enabled interrupt with the numerically lowest priority nibble. Ties go to the lowest interrupt number.
- R9: `preempt_req` is high exactly when a pending, enabled interrupt exists and its masked preemption field is strictly below `run_level`. An equal field never preempts, whatever the sub-priority.
- R10: When `irq_ack` is high while `preempt_req` is high, the offered interrupt's pending bit clears and its active bit sets. Without `preempt_req`, `irq_ack` changes nothing.
- R11: `irq_ret` clears the active bit of the running handler, and `run_level` is then recomputed from the remaining active bits. The running handler is the active interrupt with the lowest masked preemption field, ties going to the lowest number. With nothing active, `irq_ret` has no effect.
- R12: The active bits read at offset 0x200, and writes there are ignored. `run_level` is the running handler's masked priority nibble, or 16 when nothing is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Interrupt request lines, rising edge sets pending |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset (bits 1:0 ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_ack | input | 1 | Core takes the offered interrupt |
| irq_ret | input | 1 | Core returns from the running handler |
| preempt_req | output | 1 | Offered interrupt may preempt the running level |
| preempt_id | output | IW | Number of the most urgent pending, enabled interrupt |
| run_level | output | 5 | Running preemption level, 16 when idle |

## Verification
Every state change lands at one rising edge: a register write, an input edge, an acknowledge and a return all take effect there. `preempt_req`, `preempt_id`, `run_level` and `reg_rdata` follow that state combinationally, so each result is due right after the edge that consumes the stimulus. The bench drives stimulus at the falling edge and samples one time unit after the next rising edge. It reads registers between rising edges, where nothing can move. The expected values for that same cycle come from a bench model that is updated in lockstep with the clock edges.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam logic [15:0] CTRL_KEY    = 16'h05FA;
  localparam logic [11:0] OFS_STIR    = 12'hE00;
  localparam logic [11:0] OFS_CTRL    = 12'hF00;
  localparam logic [4:0]  RGN_ENS     = 5'd0;
  localparam logic [4:0]  RGN_ENC     = 5'd1;
  localparam logic [4:0]  RGN_PS      = 5'd2;
  localparam logic [4:0]  RGN_PC      = 5'd3;
  localparam logic [4:0]  RGN_ACT     = 5'd4;
  localparam logic [3:0]  RGN_PRIO_HI = 4'h3;
  localparam logic [4:0]  LVL_IDLE    = 5'h10;

  // keeps the preemption bits of a priority nibble for grouping value grp
  function automatic logic [3:0] pre_mask(input logic [2:0] grp);
    logic [3:0] m;
    m = 4'hF;
    if (grp > 3'd3) m = 4'hF << (grp - 3'd3);
    return m;
  endfunction

  function automatic logic [4:0] pre_level(input logic [3:0] prio, input logic [2:0] grp);
    return {1'b0, prio & pre_mask(grp)};
  endfunction
endpackage

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int N  = 40,
  parameter int KW = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][KW-1:0] key,
  output logic                 found,
  output logic [IW-1:0]        id,
  output logic [KW-1:0]        best
);
  // strict compare keeps the lowest index among equal keys
  always_comb begin
    found = 1'b0;
    id    = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && (!found || key[i] < best)) begin
        found = 1'b1;
        id    = IW'(i);
        best  = key[i];
      end
    end
  end
endmodule

// File: rtl/nic_bus.sv
module nic_bus
  import nic_pkg::*;
#(
  parameter int N = 40
) (
  input  logic               wr,
  input  logic [11:0]        addr,
  input  logic [31:0]        wdata,
  input  logic [N-1:0]       en_q,
  input  logic [N-1:0]       pend_q,
  input  logic [N-1:0]       act_q,
  input  logic [N-1:0][3:0]  prio_q,
  input  logic [2:0]         group_q,
  output logic [N-1:0]       en_set,
  output logic [N-1:0]       en_clr,
  output logic [N-1:0]       pend_set,
  output logic [N-1:0]       pend_clr,
  output logic [N-1:0]       prio_we,
  output logic [N-1:0][3:0]  prio_wval,
  output logic               grp_we,
  output logic [2:0]         grp_wval,
  output logic [31:0]        rdata
);
  logic [4:0] rgn;
  logic       prio_rgn;
  logic       stir_hit;

  assign rgn      = addr[11:7];
  assign prio_rgn = (addr[11:8] == RGN_PRIO_HI);
  assign stir_hit = wr && (addr == OFS_STIR);
  assign grp_we   = wr && (addr == OFS_CTRL) && (wdata[31:16] == CTRL_KEY);
  assign grp_wval = wdata[10:8];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic wsel, psel, bitv;
      wsel = wr && (addr[6:2] == 5'(i / 32));
      psel = wr && prio_rgn && (addr[7:2] == 6'(i / 4));
      bitv = wdata[i % 32];
      en_set[i]    = wsel && (rgn == RGN_ENS) && bitv;
      en_clr[i]    = wsel && (rgn == RGN_ENC) && bitv;
      pend_set[i]  = (wsel && (rgn == RGN_PS) && bitv) || (stir_hit && (wdata == 32'(i)));
      pend_clr[i]  = wsel && (rgn == RGN_PC) && bitv;
      prio_we[i]   = psel;
      prio_wval[i] = wdata[(i % 4) * 8 + 4 +: 4];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (addr[6:2] == 5'(i / 32)) begin
        if (rgn == RGN_ENS || rgn == RGN_ENC) rdata[i % 32] = en_q[i];
        if (rgn == RGN_PS  || rgn == RGN_PC)  rdata[i % 32] = pend_q[i];
        if (rgn == RGN_ACT)                   rdata[i % 32] = act_q[i];
      end
      if (prio_rgn && addr[7:2] == 6'(i / 4)) rdata[(i % 4) * 8 + 4 +: 4] = prio_q[i];
    end
    if (addr == OFS_CTRL) rdata[10:8] = group_q;
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter  int NUM_IRQ = 40,
  localparam int IW      = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               reg_wr,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               irq_ack,
  input  logic               irq_ret,
  output logic               preempt_req,
  output logic [IW-1:0]      preempt_id,
  output logic [4:0]         run_level
);
  localparam int N = NUM_IRQ;

  logic [N-1:0]      en_q, pend_q, act_q, irq_q;
  logic [N-1:0][3:0] prio_q;
  logic [2:0]        group_q;

  logic [N-1:0]      en_set, en_clr, pend_set, pend_clr, prio_we;
  logic [N-1:0][3:0] prio_wval;
  logic              grp_we;
  logic [2:0]        grp_wval;

  nic_bus #(.N(N)) u_bus (
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .pend_q(pend_q), .act_q(act_q), .prio_q(prio_q), .group_q(group_q),
    .en_set(en_set), .en_clr(en_clr), .pend_set(pend_set), .pend_clr(pend_clr),
    .prio_we(prio_we), .prio_wval(prio_wval), .grp_we(grp_we), .grp_wval(grp_wval),
    .rdata(reg_rdata)
  );

  // candidate selection: full nibble orders preemption then sub-priority
  logic          pend_found;
  logic [IW-1:0] pend_id;
  logic [3:0]    pend_best;
  nic_arbiter #(.N(N), .KW(4), .IW(IW)) u_pend_arb (
    .valid(pend_q & en_q), .key(prio_q),
    .found(pend_found), .id(pend_id), .best(pend_best)
  );

  // running handler: lowest masked field among active interrupts
  logic [N-1:0][3:0] act_key;
  always_comb begin
    for (int i = 0; i < N; i++) act_key[i] = prio_q[i] & pre_mask(group_q);
  end

  logic          act_found;
  logic [IW-1:0] act_id;
  logic [3:0]    act_best;
  nic_arbiter #(.N(N), .KW(4), .IW(IW)) u_act_arb (
    .valid(act_q), .key(act_key),
    .found(act_found), .id(act_id), .best(act_best)
  );

  // named events for the checks below
  logic [4:0]   best_level;
  logic         ack_take, ret_take;
  logic [N-1:0] irq_edge, ack_vec, ret_vec, pend_next, act_next;

  assign best_level  = pre_level(pend_best, group_q);
  assign run_level   = act_found ? {1'b0, act_best} : LVL_IDLE;
  assign preempt_req = pend_found && (best_level < run_level);
  assign preempt_id  = pend_id;
  assign ack_take    = irq_ack && preempt_req;
  assign ret_take    = irq_ret && act_found;
  assign irq_edge    = irq_in & ~irq_q;
  assign ack_vec     = ack_take ? (N'(1) << pend_id) : '0;
  assign ret_vec     = ret_take ? (N'(1) << act_id)  : '0;
  assign pend_next   = (pend_q & ~pend_clr & ~ack_vec) | irq_edge | pend_set;
  assign act_next    = (act_q & ~ret_vec) | ack_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      pend_q  <= '0;
      act_q   <= '0;
      irq_q   <= '0;
      prio_q  <= '0;
      group_q <= 3'd0;
    end else begin
      irq_q  <= irq_in;
      en_q   <= (en_q | en_set) & ~en_clr;
      pend_q <= pend_next;
      act_q  <= act_next;
      for (int i = 0; i < N; i++) begin
        if (prio_we[i]) prio_q[i] <= prio_wval[i];
      end
      if (grp_we) group_q <= grp_wval;
    end
  end

  // offered interrupt is always pending and enabled
  assert_offer_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> (en_q[preempt_id] && pend_q[preempt_id]));

  // a just-taken interrupt can never preempt its own level
  assert_no_self_preempt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !(preempt_req && preempt_id == $past(preempt_id)));

  assert_ack_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !preempt_req && !irq_ret) |=> $stable(act_q));

  assert_ret_retires_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_take && !ack_take) |=> ($countones(act_q) + 1 == $past($countones(act_q))));

  assert_unkeyed_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CTRL && reg_wdata[31:16] != CTRL_KEY) |=> $stable(group_q));

  assert_low_nibble_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[11:8] == RGN_PRIO_HI) |-> ((reg_rdata & 32'h0F0F_0F0F) == 32'h0));
endmodule

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NIRQ  = 40;
  localparam int IW    = $clog2(NIRQ);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NIRQ-1:0] irq_in = '0;
  logic            reg_wr = 1'b0;
  logic [11:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            irq_ack = 1'b0, irq_ret = 1'b0;
  logic            preempt_req;
  logic [IW-1:0]   preempt_id;
  logic [4:0]      run_level;

  int total = 0;
  int bad   = 0;

  nest_irq_ctrl #(.NUM_IRQ(NIRQ)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .preempt_req(preempt_req), .preempt_id(preempt_id), .run_level(run_level)
  );

  always #(CLK_P / 2) clk = ~clk;

  // bench model state
  logic [NIRQ-1:0] m_en, m_pend, m_act, m_irq;
  logic [3:0]      m_prio [NIRQ];
  logic [2:0]      m_grp;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // preemption bits per R7, built bit by bit from the low end
  function automatic logic [3:0] grp_mask(input logic [2:0] g);
    logic [3:0] m = 4'hF;
    for (int k = 4; k <= 7; k++) if (int'(g) >= k) m[k - 4] = 1'b0;
    return m;
  endfunction

  function automatic logic [31:0] bank_word(input logic [NIRQ-1:0] v, input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) if (w * 32 + b < NIRQ) r[b] = v[w * 32 + b];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [31:0] r = '0;
    int w = int'(a[6:2]);
    case (a[11:7])
      5'd0, 5'd1: r = bank_word(m_en, w);
      5'd2, 5'd3: r = bank_word(m_pend, w);
      5'd4:       r = bank_word(m_act, w);
      default: ;
    endcase
    if (a[11:8] == 4'h3)
      for (int b = 0; b < 4; b++)
        if (int'(a[7:2]) * 4 + b < NIRQ) r[b * 8 + 4 +: 4] = m_prio[int'(a[7:2]) * 4 + b];
    if (a == 12'hF00) r = {21'd0, m_grp, 8'd0};
    return r;
  endfunction

  // expected outputs from model state
  task automatic model_out(output logic req, output int bid, output int aid,
                           output logic af, output logic [4:0] lvl);
    logic bf = 1'b0;
    logic [3:0] mk = grp_mask(m_grp);
    bid = 0; aid = 0; af = 1'b0;
    for (int i = 0; i < NIRQ; i++) begin
      if (m_en[i] && m_pend[i] && (!bf || m_prio[i] < m_prio[bid])) begin bf = 1'b1; bid = i; end
      if (m_act[i] && (!af || (m_prio[i] & mk) < (m_prio[aid] & mk))) begin af = 1'b1; aid = i; end
    end
    lvl = af ? {1'b0, m_prio[aid] & mk} : 5'd16;
    req = bf && ({1'b0, m_prio[bid] & mk} < lvl);
  endtask

  task automatic cmp_out(input string tag);
    logic req, af; int bid, aid; logic [4:0] lvl;
    model_out(req, bid, aid, af, lvl);
    chk({tag, " req R9"}, 32'(preempt_req), 32'(req));
    chk({tag, " level R12"}, 32'(run_level), 32'(lvl));
    if (req) chk({tag, " id R8"}, 32'(preempt_id), 32'(bid));
  endtask

  task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [NIRQ-1:0] irq, input logic ack, input logic ret);
    logic req, af; int bid, aid; logic [4:0] lvl;
    logic [NIRQ-1:0] ne, np, na;
    logic [3:0] mp [NIRQ];
    logic [2:0] mg;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; irq_in = irq; irq_ack = ack; irq_ret = ret;
    model_out(req, bid, aid, af, lvl);
    ne = m_en; np = m_pend; na = m_act; mp = m_prio; mg = m_grp;
    for (int i = 0; i < NIRQ; i++) begin
      logic hit = wr && (int'(a[6:2]) == i / 32) && d[i % 32];
      if (hit && a[11:7] == 5'd0) ne[i] = 1'b1;
      if (hit && a[11:7] == 5'd1) ne[i] = 1'b0;
      if (hit && a[11:7] == 5'd3) np[i] = 1'b0;
      if (ack && req && bid == i) np[i] = 1'b0;
      if (irq[i] && !m_irq[i]) np[i] = 1'b1;
      if (hit && a[11:7] == 5'd2) np[i] = 1'b1;
      if (wr && a == 12'hE00 && d == 32'(i)) np[i] = 1'b1;
      if (wr && a[11:8] == 4'h3 && int'(a[7:2]) == i / 4) mp[i] = d[(i % 4) * 8 + 4 +: 4];
    end
    if (ret && af) na[aid] = 1'b0;
    if (ack && req) na[bid] = 1'b1;
    if (wr && a == 12'hF00 && d[31:16] == 16'h05FA) mg = d[10:8];
    @(posedge clk);
    #1;
    m_en = ne; m_pend = np; m_act = na; m_prio = mp; m_grp = mg; m_irq = irq;
    reg_wr = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, a, d, irq_in, 1'b0, 1'b0);
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    chk({tag, " model"}, reg_rdata, exp_rd(a));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_en = '0; m_pend = '0; m_act = '0; m_irq = '0; m_grp = 3'd0;
    for (int i = 0; i < NIRQ; i++) m_prio[i] = 4'h0;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    do_reset();
    #1;
    // R1 reset state
    chk("R1 req", 32'(preempt_req), 32'd0);
    chk("R1 level", 32'(run_level), 32'd16);
    rd_chk("R1 enable", 12'h000, 32'h0);
    rd_chk("R1 ctrl", 12'hF00, 32'h0);
    rd_chk("R1 prio", 12'h300, 32'h0);

    // R2 enable banks
    wr_reg(12'h000, 32'h5);
    rd_chk("R2 set", 12'h080, 32'h5);
    wr_reg(12'h080, 32'h4);
    rd_chk("R2 clear", 12'h000, 32'h1);
    wr_reg(12'h004, 32'h8);
    rd_chk("R2 word1", 12'h004, 32'h8);
    rd_chk("R2 word0 kept", 12'h000, 32'h1);

    // R5 priority slots
    wr_reg(12'h300, 32'hFFFF_FFFF);
    rd_chk("R5 nibble", 12'h300, 32'hF0F0_F0F0);
    wr_reg(12'h324, 32'h1234_5678);
    rd_chk("R5 last word", 12'h324, 32'h1030_5070);

    // R6 keyed grouping
    wr_reg(12'hF00, 32'h0000_0500);
    rd_chk("R6 no key", 12'hF00, 32'h0);
    wr_reg(12'hF00, 32'h05FA_0500);
    rd_chk("R6 keyed", 12'hF00, 32'h0000_0500);

    // R12 active bank read only
    wr_reg(12'h200, 32'hFFFF_FFFF);
    rd_chk("R12 act write ignored", 12'h200, 32'h0);

    // R4 software trigger, R3 clear-pending
    wr_reg(12'hE00, 32'd35);
    rd_chk("R4 trigger", 12'h104, 32'h8);
    wr_reg(12'h184, 32'h8);
    rd_chk("R3 clear", 12'h184, 32'h0);

    // nesting scenario, group 5: 2 preemption bits
    do_reset();
    wr_reg(12'h000, 32'h7);
    wr_reg(12'h300, 32'h0030_4060);
    wr_reg(12'hF00, 32'h05FA_0500);
    wr_reg(12'h100, 32'h3);
    chk("R8 best id", 32'(preempt_id), 32'd1);
    chk("R9 idle req", 32'(preempt_req), 32'd1);
    step(1'b0, 12'h0, 32'h0, '0, 1'b1, 1'b0);
    chk("R10 level", 32'(run_level), 32'd4);
    chk("R7 equal field no preempt R9", 32'(preempt_req), 32'd0);
    step(1'b0, 12'h0, 32'h0, '0, 1'b1, 1'b0);
    rd_chk("R10 ack ignored", 12'h200, 32'h2);
    step(1'b0, 12'h0, 32'h0, 40'h4, 1'b0, 1'b0);
    chk("R3 edge req", 32'(preempt_req), 32'd1);
    chk("R8 urgent id", 32'(preempt_id), 32'd2);
    step(1'b0, 12'h0, 32'h0, 40'h4, 1'b1, 1'b0);
    chk("R10 nested level", 32'(run_level), 32'd0);
    rd_chk("R10 nested act", 12'h200, 32'h6);
    step(1'b0, 12'h0, 32'h0, 40'h4, 1'b0, 1'b1);
    chk("R11 unwind level", 32'(run_level), 32'd4);
    chk("R11 unwind req", 32'(preempt_req), 32'd0);
    step(1'b0, 12'h0, 32'h0, 40'h4, 1'b0, 1'b1);
    chk("R11 idle level", 32'(run_level), 32'd16);
    chk("R11 idle offer", 32'(preempt_id), 32'd0);
    rd_chk("R3 held high no re-pend", 12'h100, 32'h1);
    step(1'b0, 12'h0, 32'h0, 40'h4, 1'b1, 1'b0);
    step(1'b0, 12'h0, 32'h0, 40'h4, 1'b0, 1'b1);
    step(1'b0, 12'h0, 32'h0, 40'h4, 1'b0, 1'b1);
    chk("R11 empty return", 32'(run_level), 32'd16);
    rd_chk("R11 empty act", 12'h200, 32'h0);
    cmp_out("directed");

    // constrained random against the bench model
    do_reset();
    for (int n = 0; n < 2000; n++) begin
      logic [NIRQ-1:0] irq = irq_in;
      int op = int'($urandom % 10);
      logic wr = 1'b1;
      logic [11:0] a = 12'h0;
      logic [31:0] d = $urandom;
      if ($urandom % 6 == 0) irq = irq ^ (NIRQ'(1) << ($urandom % NIRQ));
      case (op)
        0: a = 12'h000 + 12'(4 * ($urandom % 2));
        1: begin a = 12'h080 + 12'(4 * ($urandom % 2)); d = d & $urandom; end
        2: begin a = 12'h100 + 12'(4 * ($urandom % 2)); d = d & $urandom; end
        3: a = 12'h180 + 12'(4 * ($urandom % 2));
        4: a = 12'h300 + 12'(4 * ($urandom % 10));
        5: begin a = 12'hF00; if ($urandom % 2 == 0) d = {16'h05FA, d[15:0]}; end
        6: begin a = 12'hE00; d = 32'($urandom % NIRQ); end
        7: a = 12'h200;
        default: wr = 1'b0;
      endcase
      step(wr, a, d, irq, ($urandom % 2) == 0, ($urandom % 4) == 0);
      cmp_out("random");
      if (n % 16 == 0) begin
        logic [11:0] ra;
        ra = (n % 32 == 0) ? 12'h300 + 12'(4 * ($urandom % 10)) : 12'(($urandom % 5) * 128 + 4 * ($urandom % 2));
        reg_addr = ra;
        #1;
        chk("random readback R2 R3 R5", reg_rdata, exp_rd(ra));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule